// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block gives software control of up to 128 general-purpose pins, grouped into four banks of 32. Pin `p` belongs to bank `p / 32` at bit `p % 32`. Each bank has a direction word, an output latch and two alternate-function words. The output latch is never written directly. A write-one-to-set register and a write-one-to-clear register update it, so separate agents can change different pins without a read-modify-write race.

The block drives output values and output enables to the pads. A level read returns what each pin actually carries: the latch for output pins and the synchronized pad input for input pins. Whenever the value driven on a pin changes, the block raises a one-cycle change pulse for that pin, so a neighbouring model or a logger can follow the pins.

The register bus is a simple strobe interface with a registered response. The first three banks sit in a compact window. The fourth bank's level, direction, set and clear words sit in a separate window 0x100 higher.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the direction, latch and alternate-function words are zero, so `pin_oe`, `pin_out`, `pin_chg` and `alt_sel` are all zero.
- R2: A write to a bank's set word ORs the written data into that bank's latch. Set offsets: 0x018, 0x01C, 0x020 for banks 0–2 and 0x118 for bank 3. Reading a set word returns zero.
- R3: A write to a bank's clear word ANDs that bank's latch with the inverse of the data. Clear offsets: 0x024, 0x028, 0x02C for banks 0–2 and 0x124 for bank 3. Reading a clear word returns zero.
- R4: The direction word (1 = output) is read/write. Offsets: 0x00C, 0x010, 0x014 for banks 0–2 and 0x10C for bank 3. `pin_oe` equals the direction bits, and `pin_out` equals latch AND direction.
- R5: A level read returns the latch bits where direction is 1 and the synchronized input bits where direction is 0. Offsets: 0x000, 0x004, 0x008 for banks 0–2 and 0x100 for bank 3.
- R6: Pad inputs pass through two flops. A level read accepted at the first or second rising edge after a pad change still returns the old value, and one accepted at the third edge returns the new value.
- R7: In the cycle after a direction, set or clear write, `pin_chg` is 1 exactly for the pins whose `pin_out` value changed. In every other cycle `pin_chg` is zero.
- R8: Alternate-function words are fully read/write. Low words sit at 0x054+8·b and high words at 0x058+8·b for bank b. `alt_sel[64·b +: 32]` carries the low word and `alt_sel[64·b+32 +: 32]` the high word, which gives each pin a 2-bit field.
- R9: An offset at or above 0x200 reads zero, ignores writes and does not raise `bus_err`.
- R10: An offset below 0x200 that names no register (including the gaps 0x030–0x050, misaligned offsets and unused words in the 0x100 window) raises `bus_err` for one cycle, reads zero and changes no state.
- R11: `bus_rdata` and `bus_err` are registered. They are valid in the cycle after the edge that accepts the access, and `bus_rdata` is zero in any cycle not following an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Unmapped-offset flag, one cycle after the access |
| pin_in | input | 128 | Pad input levels (asynchronous) |
| pin_out | output | 128 | Driven output values |
| pin_oe | output | 128 | Output enables |
| pin_chg | output | 128 | One-cycle pulse per pin whose driven value changed |
| alt_sel | output | 256 | Alternate-function selection, two bits per pin |

## Verification
Register writes take effect at the accepting edge. The bench samples `pin_out`, `pin_oe`, `alt_sel` and `pin_chg` at the falling edge that follows that edge, and `bus_rdata` and `bus_err` at the same falling edge after a read. `pin_chg` is also checked to be zero one cycle later, during the next access. Pad inputs are changed on a falling edge, followed either by idle cycles or by reads placed exactly one, two and three edges later, which pins the two-flop input latency. Random traffic is compared against a bench model of the latch, direction and alternate-function words.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_LEVEL,
      RK_DIR,
      RK_SET,
      RK_CLR,
      RK_ALT_LO,
      RK_ALT_HI
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [1:0] bank;
   } reg_sel_t;

   localparam int unsigned MAX_BANKS   = 4;
   localparam int unsigned OFFSET_BITS = 9;   // decoded window is 0x000..0x1FF
   localparam int unsigned ALT_FIRST   = 'h54 >> 2;
   localparam int unsigned ALT_LAST    = 'h70 >> 2;

   // group index inside a window: level, direction, set, clear
   function automatic reg_kind_e group_kind(input int unsigned g);
      case (g)
         0:       return RK_LEVEL;
         1:       return RK_DIR;
         2:       return RK_SET;
         3:       return RK_CLR;
         default: return RK_NONE;
      endcase
   endfunction

   function automatic reg_sel_t decode_offset(input logic [OFFSET_BITS-1:0] off);
      reg_sel_t    r;
      int unsigned w;
      r.kind = RK_NONE;
      r.bank = 2'd0;
      w      = int'(off[7:2]);
      if (off[1:0] == 2'b00) begin
         if (!off[8]) begin
            // banks 0..2 interleaved: three consecutive words per group
            if (w < 12) begin
               r.kind = group_kind(w / 3);
               r.bank = 2'(w % 3);
            end else if (w >= ALT_FIRST && w <= ALT_LAST) begin
               r.bank = 2'((w - ALT_FIRST) >> 1);
               r.kind = ((w - ALT_FIRST) % 2 == 1) ? RK_ALT_HI : RK_ALT_LO;
            end
         end else begin
            // bank 3 window keeps the group stride of the first window
            if (w < 12 && (w % 3) == 0) begin
               r.kind = group_kind(w / 3);
               r.bank = 2'd3;
            end
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 128,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_BANKS = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel,
   output logic              in_window,
   output logic              mapped
);

   if (ADDR_W < OFFSET_BITS) begin : g_bad_addr
      $error("gpio_addr_decode: ADDR_W must cover the 0x200 window");
   end

   if (ADDR_W > OFFSET_BITS) begin : g_wide
      assign in_window = (addr[ADDR_W-1:OFFSET_BITS] == '0);
   end else begin : g_exact
      assign in_window = 1'b1;
   end

   always_comb begin
      sel    = decode_offset(addr[OFFSET_BITS-1:0]);
      mapped = in_window && (sel.kind != RK_NONE) &&
               (int'(sel.bank) < int'(NUM_BANKS));
   end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
   parameter int unsigned BANK_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_dir,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic              wr_alt_lo,
   input  logic              wr_alt_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BANK_W-1:0] in_sync,
   output logic [BANK_W-1:0] dir_q,
   output logic [BANK_W-1:0] lat_q,
   output logic [DATA_W-1:0] alt_lo_q,
   output logic [DATA_W-1:0] alt_hi_q,
   output logic [BANK_W-1:0] level,
   output logic [BANK_W-1:0] drive,
   output logic [BANK_W-1:0] chg
);

   logic [BANK_W-1:0] bits;
   logic [BANK_W-1:0] drive_prev;

   assign bits = wdata[BANK_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q    <= '0;
         lat_q    <= '0;
         alt_lo_q <= '0;
         alt_hi_q <= '0;
      end else begin
         if (wr_dir)    dir_q    <= bits;
         if (wr_set)    lat_q    <= lat_q | bits;
         else if (wr_clr) lat_q  <= lat_q & ~bits;
         if (wr_alt_lo) alt_lo_q <= wdata;
         if (wr_alt_hi) alt_hi_q <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) drive_prev <= '0;
      else        drive_prev <= drive;
   end

   assign drive = lat_q & dir_q;
   assign level = drive | (in_sync & ~dir_q);
   assign chg   = drive ^ drive_prev;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter  int unsigned NUM_BANKS   = 4,
   parameter  int unsigned BANK_W      = 32,
   parameter  int unsigned DATA_W      = 32,
   parameter  int unsigned ADDR_W      = 12,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned NPINS       = NUM_BANKS * BANK_W,
   localparam int unsigned ALT_W       = 2 * NPINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pin_chg,
   output logic [ALT_W-1:0]  alt_sel
);

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("gpio_bank_ctrl: NUM_BANKS must be 1..4");
   end
   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_width
      $error("gpio_bank_ctrl: BANK_W must be 1..DATA_W");
   end

   reg_sel_t         sel;
   logic             in_window;
   logic             mapped;
   logic [NPINS-1:0] in_sync;
   logic             wr_hit;

   gpio_addr_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_BANKS(NUM_BANKS)
   ) u_dec (
      .addr     (bus_addr),
      .sel      (sel),
      .in_window(in_window),
      .mapped   (mapped)
   );

   gpio_in_sync #(
      .WIDTH (NPINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (in_sync)
   );

   assign wr_hit = bus_sel && bus_wr && mapped;

   // per-slot views padded to the full bank count of the address map
   logic [DATA_W-1:0] rd_level [MAX_BANKS];
   logic [DATA_W-1:0] rd_dir   [MAX_BANKS];
   logic [DATA_W-1:0] rd_alt_lo[MAX_BANKS];
   logic [DATA_W-1:0] rd_alt_hi[MAX_BANKS];

   for (genvar b = 0; b < MAX_BANKS; b++) begin : g_slot
      if (b < NUM_BANKS) begin : g_bank
         logic              hit;
         logic [BANK_W-1:0] dir_q, lat_q, level, drive, chg;
         logic [DATA_W-1:0] alt_lo_q, alt_hi_q;

         assign hit = wr_hit && (int'(sel.bank) == b);

         gpio_bank_regs #(
            .BANK_W(BANK_W),
            .DATA_W(DATA_W)
         ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_dir   (hit && sel.kind == RK_DIR),
            .wr_set   (hit && sel.kind == RK_SET),
            .wr_clr   (hit && sel.kind == RK_CLR),
            .wr_alt_lo(hit && sel.kind == RK_ALT_LO),
            .wr_alt_hi(hit && sel.kind == RK_ALT_HI),
            .wdata    (bus_wdata),
            .in_sync  (in_sync[b*BANK_W +: BANK_W]),
            .dir_q    (dir_q),
            .lat_q    (lat_q),
            .alt_lo_q (alt_lo_q),
            .alt_hi_q (alt_hi_q),
            .level    (level),
            .drive    (drive),
            .chg      (chg)
         );

         assign pin_out[b*BANK_W +: BANK_W] = drive;
         assign pin_oe [b*BANK_W +: BANK_W] = dir_q;
         assign pin_chg[b*BANK_W +: BANK_W] = chg;
         assign alt_sel[2*b*BANK_W +: 2*BANK_W] =
            {alt_hi_q[BANK_W-1:0], alt_lo_q[BANK_W-1:0]};

         assign rd_level [b] = DATA_W'(level);
         assign rd_dir   [b] = DATA_W'(dir_q);
         assign rd_alt_lo[b] = alt_lo_q;
         assign rd_alt_hi[b] = alt_hi_q;
      end else begin : g_absent
         assign rd_level [b] = '0;
         assign rd_dir   [b] = '0;
         assign rd_alt_lo[b] = '0;
         assign rd_alt_hi[b] = '0;
      end
   end

   logic [DATA_W-1:0] rdata_d;

   always_comb begin
      rdata_d = '0;
      if (bus_sel && !bus_wr && mapped) begin
         case (sel.kind)
            RK_LEVEL:  rdata_d = rd_level [sel.bank];
            RK_DIR:    rdata_d = rd_dir   [sel.bank];
            RK_ALT_LO: rdata_d = rd_alt_lo[sel.bank];
            RK_ALT_HI: rdata_d = rd_alt_hi[sel.bank];
            default:   rdata_d = '0;   // set and clear words read zero
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= rdata_d;
         bus_err   <= bus_sel && in_window && !mapped;
      end
   end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NPINS  = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_err,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic [NPINS-1:0]  pin_chg
);

   logic high_access;
   assign high_access = bus_sel && (int'(bus_addr) >= 'h200);

   // R4: a pin never drives a value while its enable is off
   a_r4_out_within_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   // R7: change pulses only follow a write
   a_r7_chg_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|pin_chg) |-> $past(bus_sel && bus_wr));

   // R10: the error flag only answers an accepted access
   a_r10_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_sel));

   // R9: the upper window is silent
   a_r9_high_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      high_access |=> !bus_err);

   // R9: writes to the upper window leave the pins alone
   a_r9_high_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (high_access && bus_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

   // R11: read data is zero unless a read was accepted
   a_r11_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> (bus_rdata == '0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .NPINS (NPINS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .bus_err  (bus_err),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .pin_chg  (pin_chg)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;

   localparam int NB = 4;
   localparam int NP = 128;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_sel = 1'b0;
   logic           bus_wr = 1'b0;
   logic [11:0]    bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic           bus_err;
   logic [NP-1:0]  pin_in = '0;
   logic [NP-1:0]  pin_out, pin_oe, pin_chg;
   logic [2*NP-1:0] alt_sel;

   always #5 clk = ~clk;

   gpio_bank_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pin_chg(pin_chg), .alt_sel(alt_sel)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   // bench model
   logic [31:0] m_dir [NB];
   logic [31:0] m_lat [NB];
   logic [31:0] m_alo [NB];
   logic [31:0] m_ahi [NB];

   localparam int K_LEVEL = 0, K_DIR = 1, K_SET = 2, K_CLR = 3;

   function automatic logic [11:0] off_of(input int kind, input int bank);
      int base;
      case (kind)
         K_LEVEL: base = 'h000;
         K_DIR:   base = 'h00C;
         K_SET:   base = 'h018;
         default: base = 'h024;
      endcase
      return 12'(base + ((bank == 3) ? 'h100 : 4 * bank));
   endfunction

   function automatic logic [11:0] alt_off(input int bank, input bit hi);
      return 12'('h54 + 8 * bank + (hi ? 4 : 0));
   endfunction

   function automatic logic [NP-1:0] exp_out();
      logic [NP-1:0] v;
      for (int b = 0; b < NB; b++) v[b*32 +: 32] = m_lat[b] & m_dir[b];
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      logic [NP-1:0] v;
      for (int b = 0; b < NB; b++) v[b*32 +: 32] = m_dir[b];
      return v;
   endfunction

   function automatic logic [2*NP-1:0] exp_alt();
      logic [2*NP-1:0] v;
      for (int b = 0; b < NB; b++) v[b*64 +: 64] = {m_ahi[b], m_alo[b]};
      return v;
   endfunction

   function automatic logic [31:0] exp_level(input int b);
      return (m_lat[b] & m_dir[b]) | (pin_in[b*32 +: 32] & ~m_dir[b]);
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one access, called at a falling edge; returns at the next falling edge
   task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic er);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      rd = bus_rdata; er = bus_err;
   endtask

   // register write with model update and pin checks
   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d,
                         input int kind, input int bank, input string tag);
      logic [31:0]   rd;
      logic          er;
      logic [NP-1:0] old_out;
      old_out = exp_out();
      case (kind)
         K_DIR:   m_dir[bank] = d;
         K_SET:   m_lat[bank] = m_lat[bank] | d;
         K_CLR:   m_lat[bank] = m_lat[bank] & ~d;
         default: ;
      endcase
      access(1'b1, a, d, rd, er);
      check(pin_out == exp_out(), {tag, " pin_out"}, 256'(pin_out), 256'(exp_out()));
      check(pin_oe == exp_oe(), {tag, " pin_oe"}, 256'(pin_oe), 256'(exp_oe()));
      // R7: pulse in the cycle after the write edge
      check(pin_chg == (old_out ^ exp_out()), {tag, " R7 pin_chg"},
            256'(pin_chg), 256'(old_out ^ exp_out()));
      check(er == 1'b0, {tag, " err"}, 256'(er), 256'(0));
   endtask

   task automatic wr_alt(input int bank, input bit hi, input logic [31:0] d,
                         input string tag);
      logic [31:0] rd;
      logic        er;
      if (hi) m_ahi[bank] = d; else m_alo[bank] = d;
      access(1'b1, alt_off(bank, hi), d, rd, er);
      check(alt_sel == exp_alt(), {tag, " R8 alt_sel"}, 256'(alt_sel), 256'(exp_alt()));
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp,
                         input bit exp_err, input string tag);
      logic [31:0] rd;
      logic        er;
      access(1'b0, a, '0, rd, er);
      check(rd == exp, {tag, " rdata"}, 256'(rd), 256'(exp));
      check(er == exp_err, {tag, " err"}, 256'(er), 256'(exp_err));
      check(pin_chg == '0, {tag, " R7 no pulse"}, 256'(pin_chg), 256'(0));
   endtask

   task automatic settle_inputs(input logic [NP-1:0] v);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0]   rd;
      logic          er;
      logic [NP-1:0] snap_out;
      void'($urandom(32'd20240611));
      for (int b = 0; b < NB; b++) begin
         m_dir[b] = '0; m_lat[b] = '0; m_alo[b] = '0; m_ahi[b] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(pin_oe == '0, "R1 pin_oe", 256'(pin_oe), 256'(0));
      check(pin_out == '0, "R1 pin_out", 256'(pin_out), 256'(0));
      check(pin_chg == '0, "R1 pin_chg", 256'(pin_chg), 256'(0));
      check(alt_sel == '0, "R1 alt_sel", 256'(alt_sel), 256'(0));
      for (int b = 0; b < NB; b++) begin
         rd_chk(off_of(K_DIR, b), 32'h0, 1'b0, "R1 dir read");
         rd_chk(off_of(K_LEVEL, b), 32'h0, 1'b0, "R1 level read");
      end

      // R2: set with all pins input changes nothing visible
      wr_reg(off_of(K_SET, 0), 32'h0000_F0F0, K_SET, 0, "R2 set b0");
      // R4: direction turns the latch onto the pins
      wr_reg(off_of(K_DIR, 0), 32'h0000_00FF, K_DIR, 0, "R4 dir b0");
      rd_chk(off_of(K_DIR, 0), 32'h0000_00FF, 1'b0, "R4 dir readback");
      // R5: merged level view
      settle_inputs({96'h0, 32'hAAAA_5555});
      rd_chk(off_of(K_LEVEL, 0), exp_level(0), 1'b0, "R5 level b0");
      // R3: clear
      wr_reg(off_of(K_CLR, 0), 32'h0000_0030, K_CLR, 0, "R3 clr b0");
      rd_chk(off_of(K_SET, 0), 32'h0, 1'b0, "R2 set reads zero");
      rd_chk(off_of(K_CLR, 0), 32'h0, 1'b0, "R3 clr reads zero");

      // R9: separate bank 3 window
      wr_reg(12'h10C, 32'hFFFF_0000, K_DIR, 3, "R9 dir b3");
      wr_reg(12'h118, 32'h1234_5678, K_SET, 3, "R9 set b3");
      wr_reg(12'h124, 32'h0204_0000, K_CLR, 3, "R9 clr b3");
      rd_chk(12'h100, exp_level(3), 1'b0, "R9 level b3");

      // R8: alternate-function words
      wr_alt(0, 1'b0, 32'hDEAD_BEEF, "R8 b0 lo");
      wr_alt(2, 1'b1, 32'h0F1E_2D3C, "R8 b2 hi");
      wr_alt(3, 1'b1, 32'hC001_D00D, "R8 b3 hi");
      rd_chk(12'h054, 32'hDEAD_BEEF, 1'b0, "R8 read b0 lo");
      rd_chk(12'h068, 32'h0F1E_2D3C, 1'b0, "R8 read b2 hi");
      rd_chk(12'h070, 32'hC001_D00D, 1'b0, "R8 read b3 hi");

      // R10: unmapped offsets below 0x200
      snap_out = pin_out;
      access(1'b1, 12'h030, 32'hFFFF_FFFF, rd, er);
      check(er == 1'b1, "R10 err on 0x030 write", 256'(er), 256'(1));
      @(negedge clk);
      check(bus_err == 1'b0, "R10 err one cycle", 256'(bus_err), 256'(0));
      check(pin_out == snap_out, "R10 no state change", 256'(pin_out), 256'(snap_out));
      rd_chk(12'h00D, 32'h0, 1'b1, "R10 misaligned read");
      rd_chk(12'h104, 32'h0, 1'b1, "R10 gap in bank3 window");
      access(1'b1, 12'h110, 32'hFFFF_FFFF, rd, er);
      check(er == 1'b1, "R10 err on 0x110 write", 256'(er), 256'(1));
      rd_chk(off_of(K_DIR, 0), m_dir[0], 1'b0, "R10 dir unchanged");

      // R9: upper window reads zero, writes ignored, no error
      rd_chk(12'h200, 32'h0, 1'b0, "R9 read 0x200");
      rd_chk(12'hFFC, 32'h0, 1'b0, "R9 read 0xFFC");
      access(1'b1, 12'h20C, 32'hFFFF_FFFF, rd, er);
      check(er == 1'b0, "R9 no err on 0x20C write", 256'(er), 256'(1'b0));
      rd_chk(off_of(K_DIR, 0), m_dir[0], 1'b0, "R9 alias write ignored");

      // R11: rdata back to zero after an idle cycle
      rd_chk(12'h054, 32'hDEAD_BEEF, 1'b0, "R11 read");
      @(negedge clk);
      check(bus_rdata == 32'h0, "R11 rdata idle", 256'(bus_rdata), 256'(0));

      // R6: two-flop input latency on bank 1 (all inputs)
      pin_in[63:32] = 32'hFFFF_0000;
      rd_chk(off_of(K_LEVEL, 1), 32'h0000_0000, 1'b0, "R6 first edge old");
      rd_chk(off_of(K_LEVEL, 1), 32'h0000_0000, 1'b0, "R6 second edge old");
      rd_chk(off_of(K_LEVEL, 1), 32'hFFFF_0000, 1'b0, "R6 third edge new");

      // random traffic
      for (int i = 0; i < 400; i++) begin
         int op, b;
         logic [31:0] d;
         op = int'($urandom_range(0, 7));
         b  = int'($urandom_range(0, NB - 1));
         d  = $urandom();
         case (op)
            0: wr_reg(off_of(K_SET, b), d, K_SET, b, "R2 rand set");
            1: wr_reg(off_of(K_CLR, b), d, K_CLR, b, "R3 rand clr");
            2: wr_reg(off_of(K_DIR, b), d, K_DIR, b, "R4 rand dir");
            3: wr_alt(b, d[0], d, "R8 rand alt");
            4: rd_chk(off_of(K_LEVEL, b), exp_level(b), 1'b0, "R5 rand level");
            5: rd_chk(off_of(K_DIR, b), m_dir[b], 1'b0, "R4 rand dir read");
            6: rd_chk(alt_off(b, d[1]), d[1] ? m_ahi[b] : m_alo[b], 1'b0, "R8 rand alt read");
            default: settle_inputs({$urandom(), $urandom(), $urandom(), $urandom()});
         endcase
      end

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule